// File: doc/BRIEF.md
# Flash Command Interface with Status

This block is the command front end of a small flash-style memory. A host writes command bytes over a parallel bus. Most operations take two writes: a setup byte, then a confirm or data byte. The block decodes these sequences and starts one of two internal engines. The erase engine clears a block. The write engine programs a byte, sets a block lock or clears all locks. Each operation stays busy for a number of clock cycles set by a parameter. The stored data lives in a small register file. Programming is modelled as a bitwise AND with the old value, and erase fills a whole block with FFh.

Reads are combinational. They return either the array byte at `rd_addr` or the 8-bit status byte, chosen by the last command. FFh selects array reads. 70h, any accepted setup byte, B0h and D0h select status reads. The status byte holds:
- a ready flag;
- two suspend flags, one for erase and one for program;
- four sticky error flags.

Erase can be suspended, a program can then run, and that program can itself be suspended. Resumes unwind the innermost operation first.

The write port has a valid strobe and no ready signal, so there is no back-pressure. A write is taken in every cycle where `wr_valid` is high. A write that arrives while an engine is busy is dropped, unless it is the suspend byte.

Top module: `flash_cui`

## Requirements
- R1: After reset, status reads give 80h (ready, all flags clear), reads start in array mode, and every array byte reads FFh.
- R2: Program is 40h or 10h, then a write whose address and data give the target. While busy for PROG_CYC cycles, status bit 7 reads 0. Afterwards bit 7 reads 1 and the byte holds old AND data.
- R3: Block erase is 20h, then D0h at an address inside the block (a block is 2^BLK_W bytes). It stays busy for ERASE_CYC cycles, then every byte of that block reads FFh and other blocks are unchanged.
- R4: A 20h or 60h setup followed by a byte other than its confirm sets status bits 5 and 4 together and alters no data.
- R5: B0h during an erase gives status bit 6 = 1 and bit 7 = 1. The remaining time is frozen and the data is untouched. D0h resumes, and the erase completes after exactly the remaining cycles.
- R6: During an erase suspend, a program may run. B0h during that program sets bit 2. The first D0h resumes the program (bit 6 stays 1), and a further D0h resumes the erase.
- R7: 60h then 01h locks the block of the address, and 60h then D0h unlocks all blocks; both take LOCK_CYC cycles. A program aimed at a locked block sets bits 4 and 1, and an erase aimed at one sets bits 5 and 1. In both cases no data changes.
- R8: When `vpp_low` is high at the confirm write, program or lock-set sets bits 4 and 3, and erase or unlock sets bits 5 and 3. No operation starts.
- R9: Error bits 5, 4, 3 and 1 stay set through other commands and clear only with 50h. Status bit 0 always reads 0.
- R10: FFh switches reads to array data. After any operation or setup command, reads return status whatever `rd_addr` is.
- R11: While status bit 7 is 0, every written byte except B0h is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe; a command or data byte is taken this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Command or data byte |
| rd_addr | input | ADDR_W | Byte address to read in array mode |
| rd_data | output | 8 | Array byte or status byte |
| vpp_low | input | 1 | Programming supply too low (test input) |

## Verification
Program is tried with both setup codes, and with data that clears bits of a non-FFh byte, so a plain store is told apart from an AND. Erase, lock and voltage tests each check a neighbouring block or the target byte after the command. This shows whether a refused or completed operation touched only what it should. Suspend tests resume after a known number of elapsed cycles and check for ready on the exact remaining count, which separates a frozen timer from one that kept running or restarted. A nested erase-then-program suspend checks that the resume order is program first. A read-mode byte written during busy checks that it was dropped rather than obeyed.

// File: rtl/flash_cui_pkg.sv
`timescale 1ns/1ps
package flash_cui_pkg;

  typedef enum logic [1:0] {T_IDLE, T_RUN, T_SUSP} tmr_state_t;
  typedef enum logic [1:0] {PEND_NONE, PEND_PROG, PEND_ERASE, PEND_LOCK} pend_t;
  typedef enum logic [1:0] {WOP_PROG, WOP_LSET, WOP_LCLR} wop_t;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_PROG_A      = 8'h40;
  localparam logic [7:0] CMD_PROG_B      = 8'h10;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_LOCK        = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET    = 8'h01;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  // error vector layout: [3] erase/unlock, [2] program/lock-set, [1] supply, [0] protect
  localparam logic [3:0] ERR_SEQ       = 4'b1100;
  localparam logic [3:0] ERR_W_SUPPLY  = 4'b0110;
  localparam logic [3:0] ERR_E_SUPPLY  = 4'b1010;
  localparam logic [3:0] ERR_W_PROTECT = 4'b0101;
  localparam logic [3:0] ERR_E_PROTECT = 4'b1001;

endpackage

// File: rtl/flash_cui_timer.sv
`timescale 1ns/1ps
module flash_cui_timer
  import flash_cui_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             suspend,
  input  logic             resume,
  output logic             running,
  output logic             suspended,
  output logic             done
);

  tmr_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign running   = (state == T_RUN);
  assign suspended = (state == T_SUSP);
  assign done      = (state == T_RUN) && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= T_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        T_IDLE: if (start) begin
          state <= T_RUN;
          cnt   <= load;
        end
        T_RUN: begin
          if (cnt == CNT_W'(1)) begin
            state <= T_IDLE;
            cnt   <= '0;
          end else if (suspend) begin
            state <= T_SUSP;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        T_SUSP: if (resume) state <= T_RUN;
        default: state <= T_IDLE;
      endcase
    end
  end

  // R5: a suspended operation keeps its remaining time untouched
  p_hold_in_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == T_SUSP && !resume) |=> (state == T_SUSP && $stable(cnt)));

  // R2: completion returns the engine to idle
  p_done_then_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state == T_IDLE));

endmodule

// File: rtl/flash_cui_store.sv
`timescale 1ns/1ps
module flash_cui_store #(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 4,
  localparam int BIDX_W = ADDR_W - BLK_W,
  localparam int NBLK   = 1 << BIDX_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_do,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              erase_do,
  input  logic [BIDX_W-1:0] erase_blk,
  input  logic              lset_do,
  input  logic [BIDX_W-1:0] lset_blk,
  input  logic              lclr_do,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic [NBLK-1:0]   locks
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)
        mem[i] <= 8'hFF;
      else if (erase_do && erase_blk == BIDX_W'(i >> BLK_W))
        mem[i] <= 8'hFF;
      else if (prog_do && prog_addr == ADDR_W'(i))
        mem[i] <= mem[i] & prog_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       locks <= '0;
    else if (lclr_do) locks <= '0;
    else if (lset_do) locks[lset_blk] <= 1'b1;
  end

  assign rd_byte = mem[rd_addr];

  // R3: an erased block reads FFh from its first byte on
  p_erase_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_do |=> (mem[{$past(erase_blk), {BLK_W{1'b0}}}] == 8'hFF));

  // R2: programming never turns a 0 bit into a 1
  p_prog_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_do |=> ((mem[$past(prog_addr)] & ~$past(mem[prog_addr])) == 8'h00));

  // R7: no write reaches a locked block
  p_prog_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_do |-> !locks[prog_addr[ADDR_W-1:BLK_W]]);
  p_erase_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_do |-> !locks[erase_blk]);

endmodule

// File: rtl/flash_cui_seq.sv
`timescale 1ns/1ps
module flash_cui_seq
  import flash_cui_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 4,
  parameter int CNT_W     = 4,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 10,
  parameter int LOCK_CYC  = 3,
  localparam int BIDX_W = ADDR_W - BLK_W,
  localparam int NBLK   = 1 << BIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              vpp_low,
  input  logic [NBLK-1:0]   locks,
  input  logic              e_running,
  input  logic              e_susp,
  input  logic              e_done,
  input  logic              w_running,
  input  logic              w_susp,
  input  logic              w_done,
  output logic              e_start,
  output logic              e_suspend,
  output logic              e_resume,
  output logic [CNT_W-1:0]  e_load,
  output logic              w_start,
  output logic              w_suspend,
  output logic              w_resume,
  output logic [CNT_W-1:0]  w_load,
  output logic [7:0]        status,
  output logic              show_status,
  output logic              prog_do,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_do,
  output logic [BIDX_W-1:0] erase_blk,
  output logic              lset_do,
  output logic [BIDX_W-1:0] lset_blk,
  output logic              lclr_do
);

  pend_t             pend_q, pend_d;
  logic              show_d;
  logic [3:0]        err_q, err_set;
  logic              clr;
  wop_t              w_op_q, w_op_d;
  logic [ADDR_W-1:0] w_addr_q;
  logic [7:0]        w_data_q;
  logic [BIDX_W-1:0] e_blk_q;

  logic              ready, take, first, second, tgt_locked;
  logic [BIDX_W-1:0] wblk;

  assign ready      = !e_running && !w_running;
  assign take       = wr_valid && ready;
  assign first      = take && (pend_q == PEND_NONE);
  assign second     = take && (pend_q != PEND_NONE);
  assign wblk       = wr_addr[ADDR_W-1:BLK_W];
  assign tgt_locked = locks[wblk];

  assign e_suspend  = wr_valid && (wr_data == CMD_SUSPEND) && e_running;
  assign w_suspend  = wr_valid && (wr_data == CMD_SUSPEND) && w_running;

  always_comb begin
    pend_d   = pend_q;
    show_d   = show_status;
    err_set  = '0;
    clr      = 1'b0;
    e_start  = 1'b0;
    w_start  = 1'b0;
    e_resume = 1'b0;
    w_resume = 1'b0;
    w_op_d   = WOP_PROG;
    if (first) begin
      case (wr_data)
        CMD_READ_ARRAY:               show_d = 1'b0;
        CMD_READ_STATUS, CMD_SUSPEND: show_d = 1'b1;
        CMD_CLEAR:                    clr    = 1'b1;
        CMD_CONFIRM: begin
          show_d = 1'b1;
          if (w_susp)      w_resume = 1'b1;
          else if (e_susp) e_resume = 1'b1;
        end
        CMD_PROG_A, CMD_PROG_B: if (!w_susp) begin
          pend_d = PEND_PROG;
          show_d = 1'b1;
        end
        CMD_ERASE: if (!w_susp && !e_susp) begin
          pend_d = PEND_ERASE;
          show_d = 1'b1;
        end
        CMD_LOCK: if (!w_susp && !e_susp) begin
          pend_d = PEND_LOCK;
          show_d = 1'b1;
        end
        default: ;
      endcase
    end else if (second) begin
      pend_d = PEND_NONE;
      case (pend_q)
        PEND_PROG: begin
          if (vpp_low)         err_set = ERR_W_SUPPLY;
          else if (tgt_locked) err_set = ERR_W_PROTECT;
          else                 w_start = 1'b1;
        end
        PEND_ERASE: begin
          if (wr_data != CMD_CONFIRM) err_set = ERR_SEQ;
          else if (vpp_low)           err_set = ERR_E_SUPPLY;
          else if (tgt_locked)        err_set = ERR_E_PROTECT;
          else                        e_start = 1'b1;
        end
        PEND_LOCK: begin
          if (wr_data == CMD_LOCK_SET) begin
            w_op_d = WOP_LSET;
            if (vpp_low) err_set = ERR_W_SUPPLY;
            else         w_start = 1'b1;
          end else if (wr_data == CMD_CONFIRM) begin
            w_op_d = WOP_LCLR;
            if (vpp_low) err_set = ERR_E_SUPPLY;
            else         w_start = 1'b1;
          end else begin
            err_set = ERR_SEQ;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= PEND_NONE;
      show_status <= 1'b0;
      err_q       <= '0;
      w_op_q      <= WOP_PROG;
      w_addr_q    <= '0;
      w_data_q    <= '0;
      e_blk_q     <= '0;
    end else begin
      pend_q      <= pend_d;
      show_status <= show_d;
      err_q       <= (clr ? 4'b0000 : err_q) | err_set;
      if (w_start) begin
        w_op_q   <= w_op_d;
        w_addr_q <= wr_addr;
        w_data_q <= wr_data;
      end
      if (e_start) e_blk_q <= wblk;
    end
  end

  assign e_load = CNT_W'(ERASE_CYC);
  assign w_load = (w_op_d == WOP_PROG) ? CNT_W'(PROG_CYC) : CNT_W'(LOCK_CYC);

  assign status = {ready, e_susp, err_q[3], err_q[2], err_q[1], w_susp, err_q[0], 1'b0};

  assign prog_do   = w_done && (w_op_q == WOP_PROG);
  assign prog_addr = w_addr_q;
  assign prog_data = w_data_q;
  assign lset_do   = w_done && (w_op_q == WOP_LSET);
  assign lset_blk  = w_addr_q[ADDR_W-1:BLK_W];
  assign lclr_do   = w_done && (w_op_q == WOP_LCLR);
  assign erase_do  = e_done;
  assign erase_blk = e_blk_q;

  // R9: error flags never drop without the clear command
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R4: a broken erase sequence raises both error flags
  p_seq_err_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (second && pend_q == PEND_ERASE && wr_data != CMD_CONFIRM) |=> (err_q[3] && err_q[2]));

  // R11: writes while busy leave decode state alone
  p_busy_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !ready && wr_data != CMD_SUSPEND) |=> ($stable(pend_q) && $stable(err_q)));

endmodule

// File: rtl/flash_cui.sv
`timescale 1ns/1ps
module flash_cui #(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 4,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 10,
  parameter int LOCK_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              vpp_low
);

  localparam int BIDX_W  = ADDR_W - BLK_W;
  localparam int NBLK    = 1 << BIDX_W;
  localparam int MAX_A   = (PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC;
  localparam int MAX_CYC = (MAX_A > ERASE_CYC) ? MAX_A : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              e_start, e_suspend, e_resume, e_run, e_susp, e_done;
  logic              w_start, w_suspend, w_resume, w_run, w_susp, w_done;
  logic [CNT_W-1:0]  e_load, w_load;
  logic [7:0]        status, rd_byte;
  logic              show_status;
  logic              prog_do, erase_do, lset_do, lclr_do;
  logic [ADDR_W-1:0] prog_addr;
  logic [7:0]        prog_data;
  logic [BIDX_W-1:0] erase_blk, lset_blk;
  logic [NBLK-1:0]   locks;

  flash_cui_seq #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_low(vpp_low), .locks(locks),
    .e_running(e_run), .e_susp(e_susp), .e_done(e_done),
    .w_running(w_run), .w_susp(w_susp), .w_done(w_done),
    .e_start(e_start), .e_suspend(e_suspend), .e_resume(e_resume), .e_load(e_load),
    .w_start(w_start), .w_suspend(w_suspend), .w_resume(w_resume), .w_load(w_load),
    .status(status), .show_status(show_status),
    .prog_do(prog_do), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_do(erase_do), .erase_blk(erase_blk),
    .lset_do(lset_do), .lset_blk(lset_blk), .lclr_do(lclr_do)
  );

  flash_cui_timer #(.CNT_W(CNT_W)) u_erase_tmr (
    .clk(clk), .rst_n(rst_n), .start(e_start), .load(e_load),
    .suspend(e_suspend), .resume(e_resume),
    .running(e_run), .suspended(e_susp), .done(e_done)
  );

  flash_cui_timer #(.CNT_W(CNT_W)) u_write_tmr (
    .clk(clk), .rst_n(rst_n), .start(w_start), .load(w_load),
    .suspend(w_suspend), .resume(w_resume),
    .running(w_run), .suspended(w_susp), .done(w_done)
  );

  flash_cui_store #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .prog_do(prog_do), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_do(erase_do), .erase_blk(erase_blk),
    .lset_do(lset_do), .lset_blk(lset_blk), .lclr_do(lclr_do),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .locks(locks)
  );

  assign rd_data = show_status ? status : rd_byte;

  // R6: the two engines never count at the same time
  p_one_engine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(e_run && w_run));

endmodule

// File: tb/test_flash_cui.sv
`timescale 1ns/1ps
module test_flash_cui;

  localparam int PC = 4;
  localparam int EC = 10;
  localparam int LC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       vpp_low = 1'b0;

  int   checks = 0;
  int   fails  = 0;
  bit   rd_req = 1'b0;
  bit   finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  flash_cui #(.ADDR_W(6), .BLK_W(4), .PROG_CYC(PC), .ERASE_CYC(EC), .LOCK_CYC(LC)) i_flash_cui (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vpp_low(vpp_low)
  );

  // monitor: pops the scoreboard for every requested read, between edges
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_req) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s actual=%02h expected=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
    rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n busy slots after the starting write, then ready
  task automatic busy_then(input int n, input logic [7:0] b, input logic [7:0] r, input string t);
    rd(0, b, {t, " busy first"});
    idle(n - 2);
    rd(0, b, {t, " busy last"});
    rd(0, r, {t, " ready"});
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5, 8'hFF, "R1 array after reset");
    wr(0, 8'h70);
    rd(0, 8'h80, "R1 status after reset");

    // R2 program with 40h
    wr(0, 8'h40); wr(5, 8'hA5);
    busy_then(PC, 8'h00, 8'h80, "R2 program");
    wr(0, 8'hFF);
    rd(5, 8'hA5, "R2 programmed byte");

    // R2 / R10 program with 10h, AND behaviour, status mode
    wr(0, 8'h10); wr(5, 8'h0F);
    busy_then(PC, 8'h00, 8'h80, "R2 program 10h");
    rd(5, 8'h80, "R10 status mode after program");
    wr(0, 8'hFF);
    rd(5, 8'h05, "R2 AND with old value");
    rd(5, 8'h05, "R10 array mode");
    wr(0, 8'h40); wr(20, 8'h3C);
    busy_then(PC, 8'h00, 8'h80, "R2 program block1");

    // R3 erase block 0
    wr(0, 8'h20); wr(4, 8'hD0);
    busy_then(EC, 8'h00, 8'h80, "R3 erase");
    wr(0, 8'hFF);
    rd(5, 8'hFF, "R3 erased byte");
    rd(20, 8'h3C, "R3 other block kept");

    // R4 sequence errors
    wr(0, 8'h20); wr(4, 8'h77);
    rd(0, 8'hB0, "R4 erase sequence error");
    wr(0, 8'h50); wr(0, 8'h70);
    rd(0, 8'h80, "R9 clear after erase error");
    wr(0, 8'h60); wr(20, 8'h55);
    rd(0, 8'hB0, "R4 lock sequence error");
    wr(0, 8'h50);
    rd(0, 8'h80, "R9 clear after lock error");
    wr(0, 8'hFF);
    rd(20, 8'h3C, "R4 data untouched");

    // R7 lock block 1
    wr(0, 8'h60); wr(20, 8'h01);
    busy_then(LC, 8'h00, 8'h80, "R7 lock set");
    wr(0, 8'h40); wr(21, 8'h00);
    rd(0, 8'h92, "R7 program locked block");
    wr(0, 8'h70);
    rd(0, 8'h92, "R9 sticky through read status");
    wr(0, 8'hFF);
    rd(21, 8'hFF, "R7 locked byte unchanged");
    wr(0, 8'h50);
    wr(0, 8'h20); wr(16, 8'hD0);
    rd(0, 8'hA2, "R7 erase locked block");
    wr(0, 8'hFF);
    rd(20, 8'h3C, "R7 locked block not erased");
    wr(0, 8'h50);
    wr(0, 8'h60); wr(0, 8'hD0);
    busy_then(LC, 8'h00, 8'h80, "R7 unlock all");
    wr(0, 8'h40); wr(21, 8'h00);
    busy_then(PC, 8'h00, 8'h80, "R7 program after unlock");
    wr(0, 8'hFF);
    rd(21, 8'h00, "R7 byte written after unlock");

    // R8 supply error
    vpp_low = 1'b1;
    wr(0, 8'h40); wr(22, 8'h00);
    rd(0, 8'h98, "R8 program with low supply");
    wr(0, 8'hFF);
    rd(22, 8'hFF, "R8 byte unchanged");
    wr(0, 8'h50);
    wr(0, 8'h20); wr(16, 8'hD0);
    rd(0, 8'hA8, "R8 erase with low supply");
    wr(0, 8'h50);
    vpp_low = 1'b0;
    wr(0, 8'h70);
    rd(0, 8'h80, "R9 clear after supply error");

    // R5 erase suspend / resume on block 1
    wr(0, 8'h20); wr(16, 8'hD0);
    rd(0, 8'h00, "R5 erase running");
    wr(0, 8'hB0);
    rd(0, 8'hC0, "R5 erase suspended");
    idle(20);
    rd(0, 8'hC0, "R5 still suspended");
    wr(0, 8'hFF);
    rd(20, 8'h3C, "R5 data intact while suspended");
    wr(0, 8'hD0);
    busy_then(EC - 1, 8'h00, 8'h80, "R5 resume remaining time");
    wr(0, 8'hFF);
    rd(20, 8'hFF, "R5 erase completed");

    // R6 nested suspend
    wr(0, 8'h40); wr(40, 8'h11);
    busy_then(PC, 8'h00, 8'h80, "R6 prep program");
    wr(0, 8'h20); wr(32, 8'hD0);
    rd(0, 8'h00, "R6 erase running");
    wr(0, 8'hB0);
    rd(0, 8'hC0, "R6 erase suspended");
    wr(0, 8'h40); wr(5, 8'h5A);
    rd(0, 8'h40, "R6 program during erase suspend");
    wr(0, 8'hB0);
    rd(0, 8'hC4, "R6 both suspended");
    wr(0, 8'hFF);
    rd(5, 8'hFF, "R6 program not yet applied");
    rd(40, 8'h11, "R6 erase not yet applied");
    wr(0, 8'hD0);
    busy_then(PC - 1, 8'h40, 8'hC0, "R6 program resumes first");
    wr(0, 8'hFF);
    rd(5, 8'h5A, "R6 program applied");
    wr(0, 8'hD0);
    busy_then(EC - 1, 8'h00, 8'h80, "R6 erase resumes second");
    wr(0, 8'hFF);
    rd(40, 8'hFF, "R6 erase applied");
    rd(5, 8'h5A, "R6 other block kept");

    // R11 writes ignored while busy
    wr(0, 8'h40); wr(6, 8'h00);
    wr(6, 8'hFF);
    rd(6, 8'h00, "R11 read-array ignored while busy");
    idle(1);
    rd(6, 8'h00, "R11 still busy");
    rd(6, 8'h80, "R11 status kept after busy");
    wr(0, 8'hFF);
    rd(6, 8'h00, "R2 byte after busy test");

    idle(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule